// File: doc/BRIEF.md
# Backplane Bus Arbiter with Grant Daisy Chain

This block is the slot-1 arbiter of a backplane shared by several masters. Masters raise active-low requests on four level lines. When the shared busy line shows that the bus is idle, the arbiter drives a grant on exactly one of four level lines. It picks that level by a fixed order or by a rotating order, chosen with a mode input.

The grant passes through a chain of slot cells that is modelled inside the block. A cell that is requesting on the granted level keeps the grant and claims the bus by pulling the busy line. A cell that is not requesting on that level passes the grant to the next slot. The grant leaves the last slot on a tail output, so that requesters outside the modelled slots can also be served. If nobody claims a grant within a fixed window, the arbiter withdraws it and arbitrates again.

A built-in bus timer watches the two data strobes. It raises a bus error when a strobe stays active without an acknowledge for a configured number of clocks.

Top module: `bus_arb_chain`

## Requirements
- R1: Out of reset, no grant is driven, the busy and error lines are released (high), no request line is active, and no slot owns the bus.
- R2: In fixed mode (`rr_mode`=0), the highest-numbered active request level is granted: level 3 beats 2, 2 beats 1, and 1 beats 0.
- R3: A new grant is issued only after a clock edge at which `bbsy_n` was high. While a slot owns the bus, `bg_out` stays zero even with requests pending.
- R4: In rotating mode, the search starts one level above the level granted last, wrapping from 3 to 0, so the last granted level has the lowest priority. The last level is 0 after reset, so the first order is 1,2,3,0.
- R5: Among slots requesting on the same level, the lowest-indexed slot (the one nearest the arbiter) wins. A slot not requesting on the granted level passes the grant on, and a grant that no slot takes appears on `bg_tail`.
- R6: With `fair_en`=1, a slot that has just released the bus does not request again until its level line has been seen inactive. Another slot waiting on that level therefore wins next. With `fair_en`=0, the releasing slot may win again.
- R7: Once `bbsy_n` is seen low, the grant is removed on the next edge. A slot owns the bus from the edge after it takes the grant until the edge after it drops `slot_req`.
- R8: A grant that nobody claims stays high for exactly `CLAIM_WAIT` (64) clock cycles. It is then withdrawn for one cycle and issued again.
- R9: With `tmo_cycles`=N>0, `berr_n` goes low at the N-th clock edge at which a strobe is active (`ds_n`≠2'b11) with `dtack_n` high and no acknowledge seen so far. An acknowledge before that edge prevents the error. `tmo_cycles`=0 disables the timer.
- R10: Once asserted, `berr_n` stays low while any strobe is active, even if an acknowledge arrives. It returns high at the first edge where both strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rr_mode | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| fair_en | input | 1 | Enables fair re-request hold-off in the slot cells |
| tmo_cycles | input | TMR_W | Bus timer limit in clocks; 0 disables the timer |
| slot_req | input | NSLOT | Per-slot master wants the bus (held while it uses the bus) |
| slot_lvl | input | 2*NSLOT | Per-slot request level, 2 bits per slot |
| ext_br_n | input | 4 | Active-low requests from masters beyond the modelled slots |
| ds_n | input | 2 | Active-low data strobes |
| dtack_n | input | 1 | Active-low data acknowledge |
| br_n | output | 4 | Combined active-low request lines per level |
| bg_out | output | 4 | Grant per level leaving the arbiter |
| bg_tail | output | 4 | Grant per level leaving the last slot |
| bbsy_n | output | 1 | Active-low bus busy |
| slot_owner | output | NSLOT | One-hot owner of the bus |
| berr_n | output | 1 | Active-low bus error from the timer |

## Verification
The bench sweeps every request mask twice. First each slot has its own level, which tests the fixed order. Then all slots share one level, which tests position in the chain. A wrong priority encoder or a chain that does not block the grant would hand the bus to the wrong slot or to two slots at once. A rotating sequence checks that the pointer advances past the level just served; a design that kept the pointer would serve the same level again.

A fair and an unfair re-request race show whether the hold-off flag blocks a greedy master. An unclaimed grant is measured cycle by cycle against the 64-cycle window; an off-by-one counter would show 63 or 65. The timer is swept over limits 0 to 8 with early, late and missing acknowledges. This catches an error raised one edge early or late, and an error that drops when a late acknowledge arrives.

// File: rtl/bus_arb_chain.sv
module bus_arb_chain #(
  parameter int NSLOT      = 4,
  parameter int TMR_W      = 16,
  parameter int CLAIM_WAIT = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rr_mode,
  input  logic                 fair_en,
  input  logic [TMR_W-1:0]     tmo_cycles,
  input  logic [NSLOT-1:0]     slot_req,
  input  logic [2*NSLOT-1:0]   slot_lvl,
  input  logic [3:0]           ext_br_n,
  input  logic [1:0]           ds_n,
  input  logic                 dtack_n,
  output logic [3:0]           br_n,
  output logic [3:0]           bg_out,
  output logic [3:0]           bg_tail,
  output logic                 bbsy_n,
  output logic [NSLOT-1:0]     slot_owner,
  output logic                 berr_n
);
  localparam int CW = (CLAIM_WAIT > 1) ? $clog2(CLAIM_WAIT) : 1;
  localparam logic [CW-1:0] CW_LAST = CW'(CLAIM_WAIT - 1);

  logic [NSLOT-1:0]      owner_q, hold_q, act, claim;
  logic [NSLOT:0][3:0]   chain;
  logic [3:0]            bg_q, br_lo;
  logic [1:0]            last_q, pick;
  logic [CW-1:0]         wcnt;
  logic [TMR_W-1:0]      tcnt;
  logic                  berr_q, any_br, ds_act;

  assign bbsy_n     = ~|owner_q;
  assign slot_owner = owner_q;
  assign bg_out     = bg_q;
  assign bg_tail    = chain[NSLOT];
  assign br_n       = ~br_lo & ext_br_n;
  assign any_br     = ~&br_n;
  assign berr_n     = ~berr_q;
  assign ds_act     = ~&ds_n;

  always_comb begin
    br_lo    = '0;
    chain[0] = bg_q;
    for (int s = 0; s < NSLOT; s++) begin
      act[s]   = slot_req[s] & ~owner_q[s] & ~hold_q[s];
      chain[s+1] = chain[s];
      claim[s] = act[s] & chain[s][slot_lvl[2*s +: 2]];
      if (act[s]) begin
        br_lo[slot_lvl[2*s +: 2]]      = 1'b1;
        chain[s+1][slot_lvl[2*s +: 2]] = 1'b0;
      end
    end
  end

  always_comb begin
    pick = '0;
    if (!rr_mode) begin
      for (int l = 0; l < 4; l++)
        if (!br_n[l]) pick = 2'(l);
    end else begin
      for (int k = 4; k >= 1; k--)
        if (!br_n[2'(last_q + 2'(k))]) pick = 2'(last_q + 2'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      hold_q  <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (owner_q[s] && !slot_req[s]) begin
          owner_q[s] <= 1'b0;
          hold_q[s]  <= fair_en;
        end else if (claim[s] && bbsy_n) begin
          owner_q[s] <= 1'b1;
        end else if (hold_q[s] && br_n[slot_lvl[2*s +: 2]]) begin
          hold_q[s] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_q   <= '0;
      last_q <= '0;
      wcnt   <= '0;
    end else if (bg_q == '0) begin
      if (bbsy_n && any_br) begin
        bg_q   <= 4'b0001 << pick;
        last_q <= pick;
        wcnt   <= '0;
      end
    end else if (!bbsy_n || wcnt == CW_LAST) begin
      bg_q <= '0;
    end else begin
      wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt   <= '0;
      berr_q <= 1'b0;
    end else if (!ds_act) begin
      tcnt   <= '0;
      berr_q <= 1'b0;
    end else if (!dtack_n) begin
      tcnt <= '0;
    end else begin
      if (tmo_cycles != '0 && tcnt == tmo_cycles - 1'b1) berr_q <= 1'b1;
      if (tcnt != '1) tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_arb_chain_chk.sv
module bus_arb_chain_chk #(
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bg_out,
  input logic             bbsy_n,
  input logic [NSLOT-1:0] slot_owner,
  input logic [1:0]       ds_n,
  input logic             berr_n
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bg_out)); // R2
  AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|bg_out) |-> $past(bbsy_n)); // R3
  AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_owner)); // R5
  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bbsy_n && |bg_out) |=> (bg_out == 4'b0000)); // R7
  AST_BERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_n && ds_n != 2'b11) |=> !berr_n); // R10
  AST_BERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_n == 2'b11) |=> berr_n); // R10
endmodule

bind bus_arb_chain bus_arb_chain_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bg_out(bg_out), .bbsy_n(bbsy_n),
  .slot_owner(slot_owner), .ds_n(ds_n), .berr_n(berr_n)
);

// File: tb/bus_arb_chain_tb.sv
`timescale 1ns/1ps
module bus_arb_chain_tb;
  logic clk = 1'b0, rst_n = 1'b0, rr_mode = 1'b0, fair_en = 1'b0, dtack_n = 1'b1;
  logic [15:0] tmo_cycles = '0;
  logic [3:0]  slot_req = '0, ext_br_n = 4'hF;
  logic [7:0]  slot_lvl = 8'b11_10_01_00;
  logic [1:0]  ds_n = 2'b11;
  logic [3:0]  br_n, bg_out, bg_tail, slot_owner;
  logic        bbsy_n, berr_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_arb_chain u_dut (.clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .fair_en(fair_en),
    .tmo_cycles(tmo_cycles), .slot_req(slot_req), .slot_lvl(slot_lvl), .ext_br_n(ext_br_n),
    .ds_n(ds_n), .dtack_n(dtack_n), .br_n(br_n), .bg_out(bg_out), .bg_tail(bg_tail),
    .bbsy_n(bbsy_n), .slot_owner(slot_owner), .berr_n(berr_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_bbsy(input logic v);
    for (int i = 0; i < 20 && bbsy_n !== v; i++) @(negedge clk);
  endtask

  task automatic claim_once(input logic [3:0] mask, input logic [3:0] exp_own, input string tag);
    slot_req = mask;
    @(negedge clk);
    wait_bbsy(1'b0);
    chk(slot_owner == exp_own, tag, slot_owner, exp_own);
    slot_req = '0;
    repeat (3) @(negedge clk);
    chk(bbsy_n === 1'b1 && bg_out == 0, "R7 release", {bbsy_n, bg_out}, 5'h10);
  endtask

  function automatic logic [3:0] hi_bit(input logic [3:0] m);
    hi_bit = 0;
    for (int b = 0; b < 4; b++) if (m[b]) hi_bit = 4'(1 << b);
  endfunction
  function automatic logic [3:0] lo_bit(input logic [3:0] m);
    lo_bit = 0;
    for (int b = 3; b >= 0; b--) if (m[b]) lo_bit = 4'(1 << b);
  endfunction

  task automatic rr_step(input int exp_slot);
    @(negedge clk);
    wait_bbsy(1'b0);
    chk(slot_owner == 4'(1 << exp_slot), "R4 rotation", slot_owner, 1 << exp_slot);
    @(negedge clk); @(negedge clk);
    chk(bg_out == 0, "R3 no grant while busy", bg_out, 0);
    slot_req[exp_slot] = 1'b0;
    @(negedge clk); @(negedge clk);
    slot_req[exp_slot] = 1'b1;
  endtask

  task automatic fair_race(input logic fe, input logic [3:0] exp_own);
    fair_en = fe;
    slot_lvl = 8'b10_10_10_10;
    slot_req = 4'b0011;
    @(negedge clk);
    wait_bbsy(1'b0);
    chk(slot_owner == 4'b0001, "R5 first claim", slot_owner, 1);
    slot_req[0] = 1'b0;
    @(negedge clk);
    slot_req[0] = 1'b1;
    wait_bbsy(1'b0);
    chk(slot_owner == exp_own, "R6 fair race", slot_owner, exp_own);
    slot_req = '0;
    repeat (4) @(negedge clk);
    fair_en = 1'b0;
  endtask

  task automatic tmo_run(input int cfg, input int ack_at);
    tmo_cycles = 16'(cfg);
    @(negedge clk);
    ds_n = 2'b10;
    for (int k = 1; k <= cfg + 3; k++) begin
      @(negedge clk);
      begin
        logic exp_low;
        exp_low = (cfg != 0) && (k >= cfg) && (ack_at == 0 || cfg <= ack_at);
        chk(berr_n == !exp_low, (k > ack_at && ack_at != 0) ? "R10 berr hold" : "R9 timer",
            berr_n, !exp_low);
      end
      if (k == ack_at) dtack_n = 1'b0;
    end
    ds_n = 2'b11; dtack_n = 1'b1;
    @(negedge clk);
    chk(berr_n === 1'b1, "R10 berr clear", berr_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bg_out == 0 && bbsy_n && berr_n && br_n == 4'hF && slot_owner == 0, "R1 reset",
        {bg_out, bbsy_n, berr_n, br_n, slot_owner}, 14'h0FF0);

    for (int m = 1; m < 16; m++) claim_once(4'(m), hi_bit(4'(m)), "R2 fixed priority");

    slot_lvl = 8'b10_10_10_10;
    for (int m = 1; m < 16; m++) claim_once(4'(m), lo_bit(4'(m)), "R5 chain position");

    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rr_mode = 1'b1;
    slot_lvl = 8'b11_10_01_00;
    slot_req = 4'hF;
    rr_step(1); rr_step(2); rr_step(3); rr_step(0); rr_step(1);
    slot_req = '0;
    repeat (4) @(negedge clk);
    rr_mode = 1'b0;

    fair_race(1'b1, 4'b0010);
    fair_race(1'b0, 4'b0001);
    slot_lvl = 8'b11_10_01_00;

    ext_br_n = 4'b1101;
    for (int i = 0; i < 10 && !bg_out[1]; i++) @(negedge clk);
    chk(bg_tail == 4'b0010, "R5 grant passes to tail", bg_tail, 2);
    begin
      int hi = 0;
      while (bg_out[1] && hi < 200) begin hi++; @(negedge clk); end
      chk(hi == 64, "R8 claim window", hi, 64);
      chk(bg_out == 0, "R8 withdrawn", bg_out, 0);
      @(negedge clk);
      chk(bg_out == 4'b0010, "R8 regrant", bg_out, 2);
    end
    ext_br_n = 4'hF;
    repeat (70) @(negedge clk);

    for (int c = 0; c <= 8; c++) begin
      tmo_run(c, 0);
      tmo_run(c, 2);
      tmo_run(c, 5);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule